// File: doc/BRIEF.md
# Warp Lane Shuffle Crossbar

This block exchanges 32-bit values among the lanes of a 32-lane group in one step. Every lane presents a value. One shared delta operand, a packed options word and a 2-bit mode together decide, for each lane, which source lane's value that lane receives. Next to each result the block returns an in-bounds predicate. When the computed source lies outside the lane's subsection, the lane keeps its own value and its predicate is cleared.

The options word splits the lanes into power-of-two subsections. It does this with a section mask whose set bits mark the lane-ID bits that form the subsection address. It also carries an end-lane value that sets the boundary used by the range check. A member mask is accepted for interface compatibility and has no effect. The result is captured in registers on the clock edge that sees a valid request.

Top module: `lane_shuffle_xbar`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` and `out_pred` are loaded only on such edges and hold their value while `in_valid` is low.
- R2: While `rst_n` is low, `out_valid`, `out_pred` and `out_data` are all zero.
- R3: The section mask is `opts[12:8]` and the end-lane value is `opts[4:0]`. All other bits of `opts` have no effect on any output.
- R4: For lane L, the subsection start is `mask & L` and the subsection end is `start | (~mask & end_lane)`, both 5 bits wide. Example: mask 24 with end-lane 31 gives lane 13 a start of 8 and an end of 15.
- R5: Mode 0 (up): the source index is `L - delta`. It is out of range when the index is less than the subsection end.
- R6: Mode 1 (down): the source index is `L + delta`. It is out of range when the index is greater than the subsection end.
- R7: Mode 2 (butterfly): the source index is `L ^ delta`. It is out of range when the index is greater than the subsection end.
- R8: Mode 3 (indexed): the source index is `(delta & ~mask) | start`, with `~mask` having every bit above bit 4 set. It is out of range when the index is greater than the subsection end.
- R9: An out-of-range lane receives its own input value with predicate 0. An in-range lane receives the value of lane `index mod 32` with predicate 1. Lane L's value occupies bits `[32*L+31 : 32*L]` of the data buses, and its predicate is bit L.
- R10: `delta` is a signed two's-complement number. Index arithmetic and comparisons use its full width without truncation. Example: up mode with delta 0x80000000, mask 0 and end 0 leaves lane 3 in range, with source lane 3.
- R11: `member_mask` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| mode | input | 2 | 0 up, 1 down, 2 butterfly, 3 indexed |
| delta | input | 32 | Shared signed shift, mask or index operand |
| opts | input | 32 | Packed options: section mask [12:8], end lane [4:0] |
| member_mask | input | 32 | Participating-lane mask, ignored |
| lane_data | input | 1024 | Per-lane source values, lane L at [32L+31:32L] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 1024 | Per-lane shuffled values |
| out_pred | output | 32 | Per-lane in-range predicate |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples `in_valid`. The data, the predicate and `out_valid` all appear together, and nothing is further delayed. The bench drives a request just after a falling edge and drops `in_valid` at the next falling edge. It reads the outputs there, half a period after the capturing rising edge, so each read lands on the registered result of that one request. The hold checks read the outputs again after several idle rising edges, with the lane inputs changed in between, to show that the registers did not reload.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

   typedef enum logic [1:0] {
      SH_UP   = 2'd0,
      SH_DOWN = 2'd1,
      SH_XOR  = 2'd2,
      SH_IDX  = 2'd3
   } shfl_mode_e;

endpackage

// File: rtl/shfl_opts_decode.sv
module shfl_opts_decode #(
   parameter int OPT_W    = 32,
   parameter int LID_W    = 5,
   parameter int MASK_LSB = 8,
   parameter int END_LSB  = 0
) (
   input  logic [OPT_W-1:0] opts,
   output logic [LID_W-1:0] sect_mask,
   output logic [LID_W-1:0] end_lane
);

   localparam logic [OPT_W-1:0] FIELD_ONES = {{(OPT_W-LID_W){1'b0}}, {LID_W{1'b1}}};
   localparam logic [OPT_W-1:0] USED_BITS  = (FIELD_ONES << MASK_LSB) | (FIELD_ONES << END_LSB);

   logic unused_spare;

   assign sect_mask    = opts[MASK_LSB +: LID_W];
   assign end_lane     = opts[END_LSB +: LID_W];
   assign unused_spare = ^(opts & ~USED_BITS);

endmodule

// File: rtl/shfl_lane_route.sv
module shfl_lane_route
   import shfl_pkg::*;
#(
   parameter int LANE_ID = 0,
   parameter int LID_W   = 5,
   parameter int DELTA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chk_en,
   input  shfl_mode_e         mode,
   input  logic [DELTA_W-1:0] delta,
   input  logic [LID_W-1:0]   sect_mask,
   input  logic [LID_W-1:0]   end_lane,
   output logic [LID_W-1:0]   src_lane,
   output logic               in_bounds
);

   localparam int IDX_W = DELTA_W + 2;
   localparam int PAD_W = IDX_W - LID_W;
   localparam logic [LID_W-1:0] SELF = LID_W'(LANE_ID);

   logic [LID_W-1:0]        sub_start;
   logic [LID_W-1:0]        sub_end;
   logic signed [IDX_W-1:0] self_s;
   logic signed [IDX_W-1:0] delta_s;
   logic signed [IDX_W-1:0] start_s;
   logic signed [IDX_W-1:0] end_s;
   logic signed [IDX_W-1:0] keep_s;
   logic signed [IDX_W-1:0] idx_s;
   logic                    out_of_range;

   // subsection window of this lane
   assign sub_start = sect_mask & SELF;
   assign sub_end   = sub_start | (~sect_mask & end_lane);

   // widen everything so no index wraps before the compare
   assign self_s  = $signed({{PAD_W{1'b0}}, SELF});
   assign delta_s = $signed({{2{delta[DELTA_W-1]}}, delta});
   assign start_s = $signed({{PAD_W{1'b0}}, sub_start});
   assign end_s   = $signed({{PAD_W{1'b0}}, sub_end});
   assign keep_s  = ~$signed({{PAD_W{1'b0}}, sect_mask});

   always_comb begin
      unique case (mode)
         SH_UP:   idx_s = self_s - delta_s;
         SH_DOWN: idx_s = self_s + delta_s;
         SH_XOR:  idx_s = self_s ^ delta_s;
         SH_IDX:  idx_s = (delta_s & keep_s) | start_s;
         default: idx_s = self_s;
      endcase
   end

   always_comb begin
      if (mode == SH_UP) out_of_range = (idx_s < end_s);
      else               out_of_range = (idx_s > end_s);
   end

   assign in_bounds = ~out_of_range;
   assign src_lane  = out_of_range ? SELF : idx_s[LID_W-1:0];

   // R8: an indexed read never leaves the caller's subsection
   assert_idx_in_section_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && mode == SH_IDX && in_bounds) |-> ((src_lane & sect_mask) == (SELF & sect_mask)));

   // R6: a non-negative down shift that stays in range reads at or above this lane
   assert_down_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && mode == SH_DOWN && !delta[DELTA_W-1] && in_bounds) |-> (src_lane >= SELF));

   // R5: a non-negative up shift that stays in range reads at or below this lane
   assert_up_backward_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && mode == SH_UP && !delta[DELTA_W-1] && in_bounds) |-> (src_lane <= SELF));

endmodule

// File: rtl/shfl_lane_pick.sv
module shfl_lane_pick #(
   parameter int LANES  = 32,
   parameter int DATA_W = 32,
   localparam int LID_W = $clog2(LANES)
) (
   input  logic [LANES*DATA_W-1:0] all_data,
   input  logic [LID_W-1:0]        sel,
   output logic [DATA_W-1:0]       picked
);

   logic [DATA_W-1:0] bank [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_bank
      assign bank[g] = all_data[g*DATA_W +: DATA_W];
   end

   assign picked = bank[sel];

endmodule

// File: rtl/lane_shuffle_xbar.sv
module lane_shuffle_xbar
   import shfl_pkg::*;
#(
   parameter int LANES    = 32,
   parameter int DATA_W   = 32,
   parameter int DELTA_W  = 32,
   parameter int OPT_W    = 32,
   parameter int MASK_LSB = 8,
   parameter int END_LSB  = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              mode,
   input  logic [DELTA_W-1:0]      delta,
   input  logic [OPT_W-1:0]        opts,
   input  logic [LANES-1:0]        member_mask,
   input  logic [LANES*DATA_W-1:0] lane_data,
   output logic                    out_valid,
   output logic [LANES*DATA_W-1:0] out_data,
   output logic [LANES-1:0]        out_pred
);

   localparam int LID_W = $clog2(LANES);

   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (DELTA_W <= LID_W) begin : g_bad_delta
      $error("DELTA_W must exceed the lane-ID width");
   end
   if (MASK_LSB + LID_W > OPT_W || END_LSB + LID_W > OPT_W) begin : g_bad_opt_pos
      $error("option fields do not fit in OPT_W");
   end
   if (!(MASK_LSB >= END_LSB + LID_W || END_LSB >= MASK_LSB + LID_W)) begin : g_bad_opt_overlap
      $error("option fields overlap");
   end

   shfl_mode_e              mode_e;
   logic [LID_W-1:0]        sect_mask;
   logic [LID_W-1:0]        end_lane;
   logic [LANES*DATA_W-1:0] next_data;
   logic [LANES-1:0]        next_pred;
   logic                    unused_member;

   assign mode_e        = shfl_mode_e'(mode);
   assign unused_member = ^member_mask;

   shfl_opts_decode #(
      .OPT_W    (OPT_W),
      .LID_W    (LID_W),
      .MASK_LSB (MASK_LSB),
      .END_LSB  (END_LSB)
   ) u_opts (
      .opts      (opts),
      .sect_mask (sect_mask),
      .end_lane  (end_lane)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LID_W-1:0]  src;
      logic              ok;
      logic [DATA_W-1:0] val;

      shfl_lane_route #(
         .LANE_ID (g),
         .LID_W   (LID_W),
         .DELTA_W (DELTA_W)
      ) u_route (
         .clk       (clk),
         .rst_n     (rst_n),
         .chk_en    (in_valid),
         .mode      (mode_e),
         .delta     (delta),
         .sect_mask (sect_mask),
         .end_lane  (end_lane),
         .src_lane  (src),
         .in_bounds (ok)
      );

      shfl_lane_pick #(
         .LANES  (LANES),
         .DATA_W (DATA_W)
      ) u_pick (
         .all_data (lane_data),
         .sel      (src),
         .picked   (val)
      );

      assign next_data[g*DATA_W +: DATA_W] = val;
      assign next_pred[g]                  = ok;

      // R9: a cleared predicate means the lane got back its own operand
      assert_fallback_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_pred[g]) |-> (out_data[g*DATA_W +: DATA_W] == $past(lane_data[g*DATA_W +: DATA_W])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_pred  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= next_data;
            out_pred <= next_pred;
         end
      end
   end

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_pred)));

endmodule

// File: tb/test_lane_shuffle_xbar.sv
`timescale 1ns/1ps
module test_lane_shuffle_xbar;

   localparam int LANES = 32;
   localparam int DW    = 32;

   typedef struct packed {
      logic [1:0]  mode;
      logic [31:0] delta;
      logic [31:0] opts;
      logic [4:0]  probe;
      logic [4:0]  exp_src;
      logic        exp_pred;
   } vec_t;

   localparam int NVEC = 17;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 32'h0000_0001, 32'h0000_0000, 5'd0,  5'd0,  1'b0},  // R5 below end
      '{2'd0, 32'h0000_0001, 32'h0000_0000, 5'd5,  5'd4,  1'b1},  // R5
      '{2'd1, 32'h0000_0003, 32'h0000_001F, 5'd30, 5'd30, 1'b0},  // R6 past end
      '{2'd1, 32'h0000_0003, 32'h0000_001F, 5'd10, 5'd13, 1'b1},  // R6
      '{2'd2, 32'h0000_0001, 32'h0000_001F, 5'd6,  5'd7,  1'b1},  // R7
      '{2'd2, 32'h0000_0010, 32'h0000_181F, 5'd13, 5'd13, 1'b0},  // R7 R4 leaves width-8 section
      '{2'd2, 32'h0000_0004, 32'h0000_181F, 5'd13, 5'd9,  1'b1},  // R7 R4
      '{2'd3, 32'h0000_0002, 32'h0000_181F, 5'd13, 5'd10, 1'b1},  // R8
      '{2'd3, 32'h0000_0023, 32'h0000_181F, 5'd13, 5'd13, 1'b0},  // R8 upper delta bit kept
      '{2'd1, 32'h0000_0003, 32'h0000_181F, 5'd14, 5'd14, 1'b0},  // R6 R4
      '{2'd1, 32'h0000_0003, 32'h0000_181F, 5'd12, 5'd15, 1'b1},  // R6 R4 edge
      '{2'd0, 32'h0000_0002, 32'h0000_1800, 5'd9,  5'd9,  1'b0},  // R5 R4
      '{2'd0, 32'h0000_0002, 32'h0000_1800, 5'd10, 5'd8,  1'b1},  // R5 R4 edge
      '{2'd1, 32'hFFFF_FFFF, 32'h0000_001F, 5'd0,  5'd31, 1'b1},  // R10 negative down
      '{2'd0, 32'h8000_0000, 32'h0000_0000, 5'd3,  5'd3,  1'b1},  // R10 no truncation
      '{2'd2, 32'hFFFF_FFE0, 32'h0000_001F, 5'd5,  5'd5,  1'b1},  // R10 negative xor
      '{2'd2, 32'h0000_0001, 32'hFFFF_E0FF, 5'd6,  5'd7,  1'b1}   // R3 spare bits set
   };

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 in_valid;
   logic [1:0]           mode;
   logic [31:0]          delta;
   logic [31:0]          opts;
   logic [LANES-1:0]     member_mask;
   logic [LANES*DW-1:0]  lane_data;
   logic                 out_valid;
   logic [LANES*DW-1:0]  out_data;
   logic [LANES-1:0]     out_pred;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lane_shuffle_xbar i_lane_shuffle_xbar (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .mode        (mode),
      .delta       (delta),
      .opts        (opts),
      .member_mask (member_mask),
      .lane_data   (lane_data),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_pred    (out_pred)
   );

   function automatic logic [31:0] pat(input logic [15:0] seed, input int l);
      return {seed, 8'h5A, 8'(l)};
   endfunction

   // expected routing from the requirements
   function automatic void model(input logic [1:0] m, input logic [31:0] d, input logic [31:0] o,
                                 input int lane, output int src, output bit pred);
      longint ds, msk, en, st, ed, idx;
      bit oob;
      ds  = longint'($signed(d));
      msk = longint'(o[12:8]);
      en  = longint'(o[4:0]);
      st  = msk & longint'(lane);
      ed  = (st | (~msk & en)) & 31;
      case (m)
         2'd0:    idx = longint'(lane) - ds;
         2'd1:    idx = longint'(lane) + ds;
         2'd2:    idx = longint'(lane) ^ ds;
         default: idx = (ds & ~msk) | st;
      endcase
      oob  = (m == 2'd0) ? (idx < ed) : (idx > ed);
      src  = oob ? lane : int'(idx & 31);
      pred = !oob;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] m, input logic [31:0] d, input logic [31:0] o,
                        input logic [31:0] mm, input logic [15:0] seed);
      @(negedge clk);
      mode        = m;
      delta       = d;
      opts        = o;
      member_mask = mm;
      for (int l = 0; l < LANES; l++) lane_data[l*DW +: DW] = pat(seed, l);
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
   endtask

   task automatic full_check(input logic [1:0] m, input logic [31:0] d, input logic [31:0] o,
                             input logic [15:0] seed, input int vi);
      int bad = 0;
      int first_l = -1;
      logic [32:0] first_act = '0;
      logic [32:0] first_exp = '0;
      for (int l = 0; l < LANES; l++) begin
         int s;
         bit p;
         model(m, d, o, l, s, p);
         if (out_data[l*DW +: DW] !== pat(seed, s) || out_pred[l] !== p) begin
            if (bad == 0) begin
               first_l   = l;
               first_act = {out_pred[l], out_data[l*DW +: DW]};
               first_exp = {p, pat(seed, s)};
            end
            bad++;
         end
      end
      check(bad == 0, "R9", $sformatf("vector %0d all lanes (first bad lane %0d)", vi, first_l),
            64'(first_act), 64'(first_exp));
   endtask

   initial begin
      rst_n       = 1'b0;
      in_valid    = 1'b0;
      mode        = 2'd0;
      delta       = '0;
      opts        = '0;
      member_mask = '0;
      lane_data   = '0;
      repeat (3) @(negedge clk);

      // R2 reset state
      check(out_valid === 1'b0, "R2", "out_valid in reset", 64'(out_valid), 64'd0);
      check(out_pred === '0 && out_data === '0, "R2", "pred/data in reset",
            64'(out_pred), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] seed;
         logic [31:0] exp_word;
         seed = 16'(16'h1000 + v);
         apply(VECS[v].mode, VECS[v].delta, VECS[v].opts, 32'hA5A5_0F0F, seed);
         check(out_valid === 1'b1, "R1", $sformatf("vector %0d out_valid", v), 64'(out_valid), 64'd1);
         exp_word = pat(seed, int'(VECS[v].exp_src));
         check(out_data[int'(VECS[v].probe)*DW +: DW] === exp_word &&
               out_pred[int'(VECS[v].probe)] === VECS[v].exp_pred,
               "R4-R10 probe", $sformatf("vector %0d lane %0d", v, VECS[v].probe),
               64'({out_pred[int'(VECS[v].probe)], out_data[int'(VECS[v].probe)*DW +: DW]}),
               64'({VECS[v].exp_pred, exp_word}));
         full_check(VECS[v].mode, VECS[v].delta, VECS[v].opts, seed, v);
      end

      // R1 idle: valid drops, outputs hold while inputs move
      begin
         logic [LANES*DW-1:0] held_d;
         logic [LANES-1:0]    held_p;
         held_d = out_data;
         held_p = out_pred;
         for (int l = 0; l < LANES; l++) lane_data[l*DW +: DW] = 32'hDEAD_0000 | 32'(l);
         mode  = 2'd1;
         delta = 32'd1;
         repeat (3) @(negedge clk);
         check(out_valid === 1'b0, "R1", "out_valid idle", 64'(out_valid), 64'd0);
         check(out_data === held_d && out_pred === held_p, "R1", "outputs held while idle",
               64'(out_pred), 64'(held_p));
      end

      // R11 member mask has no effect
      begin
         logic [LANES*DW-1:0] d0;
         logic [LANES-1:0]    p0;
         apply(2'd2, 32'h0000_0010, 32'h0000_181F, 32'h0000_0000, 16'h7777);
         d0 = out_data;
         p0 = out_pred;
         apply(2'd2, 32'h0000_0010, 32'h0000_181F, 32'hFFFF_FFFF, 16'h7777);
         check(out_data === d0 && out_pred === p0, "R11", "member mask 0 vs all ones",
               64'(out_pred), 64'(p0));
      end

      // R3 spare option bits: same fields, different padding
      begin
         logic [LANES*DW-1:0] d0;
         logic [LANES-1:0]    p0;
         apply(2'd3, 32'h0000_0005, 32'h0000_101F, 32'h0, 16'h3333);
         d0 = out_data;
         p0 = out_pred;
         apply(2'd3, 32'h0000_0005, 32'hABCD_F0FF & 32'hFFFF_F0FF | 32'h0000_101F, 32'h0, 16'h3333);
         check(out_data === d0 && out_pred === p0, "R3", "spare opts bits ignored",
               64'(out_pred), 64'(p0));
      end

      // R2 reset in mid-run clears registered state
      apply(2'd1, 32'd2, 32'h0000_001F, 32'h0, 16'h4444);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(out_valid === 1'b0 && out_pred === '0 && out_data === '0, "R2", "mid-run reset",
            64'(out_pred), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule